// File: doc/BRIEF.md
# Two-Stage Countdown Watchdog

The block is a countdown watchdog with a small register file on a simple I/O bus. The bus has a byte address, 16-bit write data, two byte enables, a write strobe and combinational read data. An external tick enable decrements the counter once per pulse, with one tick every 0.6 s. Software converts a timeout in seconds to ticks as seconds×10/6 and programs that value as the initial value. Software restarts the count by writing anything to the reload register. It can halt the counter or let it run, and it can read the live count.

The first time the count runs out, the block sets a sticky first-timeout flag, pulses an interrupt and reloads the counter. If the count runs out again while that flag is still set, the block sets the second-timeout and boot flags and stops counting until the next reload. It also raises a one-cycle reset request, unless the no-reboot lock bit is set. Status flags are cleared by writing 1 to them.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the registers read as follows: byte 0x08 reads 0x0801 (halt = 1, no-reboot = 1), the initial value at 0x12 reads 0x0004, the count at 0x00 reads 0x0004, the status bytes at 0x04 and 0x06 read 0, and irq_o and rst_req_o are low.
- R2: The initial value is held in bits [9:0] of the word at 0x12, and bits [15:10] read 0. A write merges the enabled bytes with the current value. A merged value of 0 to 3 is ignored and the previous value is kept.
- R3: Any write to byte 0x00 loads the count with the initial value. Reading 0x00 returns the count in bits [9:0].
- R4: With halt (bit 11 of 0x08) at 0, each tick lowers a nonzero count by one. With halt at 1, ticks leave the count unchanged.
- R5: A tick at count 0 with the first-timeout flag (bit 3 of 0x04) clear is a first expiry. It sets that flag, pulses irq_o for one cycle in the cycle after the tick, and reloads the count with the initial value.
- R6: A tick at count 0 with the first-timeout flag set is a second expiry. It sets the second-timeout flag (bit 1 of 0x06) and the boot flag (bit 2 of 0x06). The count then stays at 0 through later ticks until a reload write, after which counting resumes.
- R7: rst_req_o is a one-cycle pulse in the cycle after a second expiry, and it is raised only when no-reboot (bit 0 of 0x08) is 0.
- R8: Writing 1 to a status flag clears it and writing 0 leaves it unchanged. A flag set in the same cycle as a clear write stays set.
- R9: The halt and no-reboot bits read back the last value written to them.
- R10: A reload write in the same cycle as a tick loads the initial value, and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one pulse per 0.6 s |
| addr_i | input | 5 | Byte address within the 32-byte window |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables for the low and high byte |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| irq_o | output | 1 | First-expiry pulse |
| rst_req_o | output | 1 | Second-expiry reset request pulse |

## Verification
A register write or a tick takes effect at the clock edge on which it is sampled. Read data follows the address combinationally, so a value written is visible one cycle after the write strobe. irq_o and rst_req_o are registered, so each is high only during the cycle that follows the expiring tick. The bench drives inputs on the falling edge and holds each tick or write for exactly one rising edge. It samples on the next falling edge, which is when every result is due, and it checks one cycle later that the pulses have dropped.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  // word index = byte offset / 2
  localparam logic [3:0] W_RELOAD = 4'h0;
  localparam logic [3:0] W_STAT1  = 4'h2;
  localparam logic [3:0] W_STAT2  = 4'h3;
  localparam logic [3:0] W_CTRL   = 4'h4;
  localparam logic [3:0] W_INIT   = 4'h9;
  localparam int HALT_BIT = 11;
  localparam int NORB_BIT = 0;
  localparam int TO1_BIT  = 3;
  localparam int TO2_BIT  = 1;
  localparam int BOOT_BIT = 2;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 10,
  parameter int RST_INIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             first_i,
  input  logic             no_reboot_i,
  output logic [CNT_W-1:0] count_o,
  output logic             exp1_o,
  output logic             exp2_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] count_q;
  logic             stall_q;
  logic             expire;

  assign expire  = tick_i && run_i && !stall_q && !reload_i && (count_q == '0);
  assign exp1_o  = expire && !first_i;
  assign exp2_o  = expire && first_i;
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= CNT_W'(RST_INIT);
      stall_q   <= 1'b0;
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= exp1_o;
      rst_req_o <= exp2_o && !no_reboot_i;
      if (reload_i) begin
        count_q <= init_i;
        stall_q <= 1'b0;
      end else if (exp1_o) begin
        count_q <= init_i;
      end else if (exp2_o) begin
        stall_q <= 1'b1;
      end else if (tick_i && run_i && !stall_q) begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  assert_halt_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reload_i) |=> $stable(count_q));
  assert_reload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (count_q == $past(init_i)));
  assert_rst_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !$past(no_reboot_i));
  assert_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  assert_irq_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_no_both_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MIN_INIT = 4,
  parameter int RST_INIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              exp1_i,
  input  logic              exp2_i,
  input  logic              irq_i,
  output logic              reload_o,
  output logic [CNT_W-1:0]  init_o,
  output logic              run_o,
  output logic              first_o,
  output logic              no_reboot_o
);
  logic [3:0]        widx;
  logic [CNT_W-1:0]  init_q;
  logic              halt_q, norb_q, to1_q, to2_q, boot_q;
  logic [DATA_W-1:0] init_old, init_mrg;
  logic [CNT_W-1:0]  init_new;
  logic              wr_init, wr_ctrl, wr_st1, wr_st2, init_ok;

  assign widx     = addr_i[ADDR_W-1:1];
  assign wr_init  = we_i && (widx == W_INIT);
  assign wr_ctrl  = we_i && (widx == W_CTRL);
  assign wr_st1   = we_i && (widx == W_STAT1) && be_i[0];
  assign wr_st2   = we_i && (widx == W_STAT2) && be_i[0];
  assign reload_o = we_i && (widx == W_RELOAD);

  assign init_old = DATA_W'(init_q);
  assign init_mrg = {be_i[1] ? wdata_i[15:8] : init_old[15:8],
                     be_i[0] ? wdata_i[7:0]  : init_old[7:0]};
  assign init_new = init_mrg[CNT_W-1:0];
  assign init_ok  = (init_new >= CNT_W'(MIN_INIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= CNT_W'(RST_INIT);
      halt_q <= 1'b1;
      norb_q <= 1'b1;
      to1_q  <= 1'b0;
      to2_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      if (wr_init && init_ok) init_q <= init_new;
      if (wr_ctrl && be_i[1]) halt_q <= wdata_i[HALT_BIT];
      if (wr_ctrl && be_i[0]) norb_q <= wdata_i[NORB_BIT];
      // set wins over write-one-to-clear
      if (exp1_i) to1_q <= 1'b1;
      else if (wr_st1 && wdata_i[TO1_BIT]) to1_q <= 1'b0;
      if (exp2_i) to2_q <= 1'b1;
      else if (wr_st2 && wdata_i[TO2_BIT]) to2_q <= 1'b0;
      if (exp2_i) boot_q <= 1'b1;
      else if (wr_st2 && wdata_i[BOOT_BIT]) boot_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (widx)
      W_RELOAD: rdata_o = DATA_W'(count_i);
      W_STAT1:  rdata_o[TO1_BIT] = to1_q;
      W_STAT2:  begin rdata_o[TO2_BIT] = to2_q; rdata_o[BOOT_BIT] = boot_q; end
      W_CTRL:   begin rdata_o[HALT_BIT] = halt_q; rdata_o[NORB_BIT] = norb_q; end
      W_INIT:   rdata_o = DATA_W'(init_q);
      default:  rdata_o = '0;
    endcase
  end

  assign init_o      = init_q;
  assign run_o       = !halt_q;
  assign first_o     = to1_q;
  assign no_reboot_o = norb_q;

  assert_bad_init_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_init && !init_ok) |=> $stable(init_q));
  assert_flag_on_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> to1_q);
  assert_boot_with_second_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to2_q) |-> boot_q);
  assert_set_beats_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp1_i |=> to1_q);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MIN_INIT = 4,
  parameter int RST_INIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] count, init;
  logic exp1, exp2, reload, run, first, norb;

  wdt_regs #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT), .RST_INIT(RST_INIT)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .be_i, .we_i, .rdata_o,
    .count_i(count), .exp1_i(exp1), .exp2_i(exp2), .irq_i(irq_o),
    .reload_o(reload), .init_o(init), .run_o(run), .first_o(first),
    .no_reboot_o(norb)
  );

  wdt_counter #(.CNT_W(CNT_W), .RST_INIT(RST_INIT)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .run_i(run), .reload_i(reload), .init_i(init),
    .first_i(first), .no_reboot_i(norb), .count_o(count), .exp1_o(exp1),
    .exp2_o(exp2), .irq_o, .rst_req_o
  );
endmodule

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;
  logic        clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [4:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [1:0]  be = 0;
  logic        irq, rst_req;
  int total = 0, bad = 0;
  logic [15:0] r;

  always #2 clk = ~clk;

  wdt_two_stage uut (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .we_i(we), .rdata_o(rdata), .irq_o(irq),
    .rst_req_o(rst_req));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] b);
    addr = a; wdata = d; be = b; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  function automatic logic [15:0] after_ticks(input int init, input int k);
    return 16'(init - k);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'h00, r); chk("R1 count", r, 16'h0004);
    rd(5'h04, r); chk("R1 st1", r, 16'h0000);
    rd(5'h06, r); chk("R1 st2", r, 16'h0000);
    rd(5'h08, r); chk("R1 ctrl", r, 16'h0801);
    rd(5'h12, r); chk("R1 init", r, 16'h0004);
    chk("R1 pulses", {14'b0, irq, rst_req}, 16'h0000);
    // R4 halted at reset
    tk(3); rd(5'h00, r); chk("R4 halted", r, 16'h0004);
    // R9 readback
    wr(5'h08, 16'h0000, 2'b11); rd(5'h08, r); chk("R9 clear", r, 16'h0000);
    wr(5'h08, 16'h0801, 2'b11); rd(5'h08, r); chk("R9 set", r, 16'h0801);
    wr(5'h08, 16'h0000, 2'b01); rd(5'h08, r); chk("R9 low byte only", r, 16'h0800);
    // R2 init field
    wr(5'h12, 16'h0002, 2'b11); rd(5'h12, r); chk("R2 illegal ignored", r, 16'h0004);
    wr(5'h12, 16'hFC07, 2'b11); rd(5'h12, r); chk("R2 upper bits", r, 16'h0007);
    wr(5'h12, 16'h0100, 2'b10); rd(5'h12, r); chk("R2 high byte merge", r, 16'h0107);
    wr(5'h12, 16'h0002, 2'b01); rd(5'h12, r); chk("R2 low byte merge", r, 16'h0102);
    wr(5'h12, 16'h0003, 2'b11); rd(5'h12, r); chk("R2 three ignored", r, 16'h0102);
    wr(5'h12, 16'h03FF, 2'b11); rd(5'h12, r); chk("R2 max", r, 16'h03FF);
    // R3, R4 random
    wr(5'h08, 16'h0001, 2'b11);
    for (int it = 0; it < 16; it++) begin
      int v, k;
      v = 4 + int'($urandom % 60);
      k = int'($urandom % v);
      wr(5'h12, 16'(v), 2'b11);
      wr(5'h00, 16'(it), 2'b11);
      rd(5'h00, r); chk("R3 reload", r, 16'(v));
      tk(k);
      rd(5'h00, r); chk("R4 decrement", r, after_ticks(v, k));
      if (it % 4 == 0) begin
        wr(5'h08, 16'h0801, 2'b11); tk(2);
        rd(5'h00, r); chk("R4 halt freeze", r, after_ticks(v, k));
        wr(5'h08, 16'h0001, 2'b11);
      end
    end
    // R5, R6, R7 with no-reboot = 0
    wr(5'h08, 16'h0000, 2'b11);
    wr(5'h12, 16'h0005, 2'b11);
    wr(5'h00, 16'h0001, 2'b01);
    tk(5); rd(5'h00, r); chk("R4 at zero", r, 16'h0000);
    tk(1); #1;
    chk("R5 irq", {15'b0, irq}, 16'h0001);
    chk("R5 no rst", {15'b0, rst_req}, 16'h0000);
    rd(5'h00, r); chk("R5 reloaded", r, 16'h0005);
    rd(5'h04, r); chk("R5 flag", r, 16'h0008);
    @(negedge clk); chk("R5 irq one cycle", {15'b0, irq}, 16'h0000);
    wr(5'h04, 16'h0000, 2'b01); rd(5'h04, r); chk("R8 write zero keeps", r, 16'h0008);
    tk(5); tk(1); #1;
    chk("R7 rst pulse", {15'b0, rst_req}, 16'h0001);
    chk("R6 no irq", {15'b0, irq}, 16'h0000);
    rd(5'h00, r); chk("R6 count zero", r, 16'h0000);
    rd(5'h06, r); chk("R6 flags", r, 16'h0006);
    @(negedge clk); chk("R7 one cycle", {15'b0, rst_req}, 16'h0000);
    tk(3); rd(5'h00, r); chk("R6 stuck", r, 16'h0000);
    chk("R6 no repeat", {14'b0, irq, rst_req}, 16'h0000);
    wr(5'h00, 16'h0001, 2'b01); tk(1);
    rd(5'h00, r); chk("R6 resume", r, 16'h0004);
    // R8 clears
    wr(5'h04, 16'h0008, 2'b01); rd(5'h04, r); chk("R8 clear to1", r, 16'h0000);
    wr(5'h06, 16'h0002, 2'b01); rd(5'h06, r); chk("R8 clear to2", r, 16'h0004);
    wr(5'h06, 16'h0004, 2'b01); rd(5'h06, r); chk("R8 clear boot", r, 16'h0000);
    // R7 no-reboot lock
    wr(5'h08, 16'h0001, 2'b11);
    wr(5'h12, 16'h0004, 2'b11);
    wr(5'h00, 16'h0001, 2'b01);
    tk(5); #1; chk("R5 second run irq", {15'b0, irq}, 16'h0001);
    @(negedge clk);
    tk(5); #1; chk("R7 locked no rst", {15'b0, rst_req}, 16'h0000);
    rd(5'h06, r); chk("R7 locked flags", r, 16'h0006);
    // R10 reload beats tick
    wr(5'h04, 16'h0008, 2'b01);
    wr(5'h06, 16'h0006, 2'b01);
    wr(5'h12, 16'h0009, 2'b11);
    wr(5'h00, 16'h0001, 2'b01);
    tk(4);
    addr = 5'h00; wdata = 16'h0001; be = 2'b01; we = 1; tick = 1;
    @(negedge clk); we = 0; tick = 0;
    rd(5'h00, r); chk("R10 reload wins", r, 16'h0009);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule